// File: doc/BRIEF.md
# Address Watchpoint Match Unit

This block is a debug watchpoint for a 32-bit processor. Software programs two registers through a small select/write-enable/read-data port. The first register holds a watched virtual address and three enables, one each for instruction fetches, loads and stores. The second register holds a qualifier: an address-space identifier, a global bit and an address mask.

Each cycle the unit compares the fetch address and the data address in parallel against the watched address. The comparison works on aligned doublewords. It is qualified by the mask and, unless the global bit is set, by the current address-space identifier. A hit on an enabled access type produces a watch exception request one cycle later.

While the processor runs at exception level or error level, the request is not raised. Instead, a sticky pending bit is set, and the deferred request is delivered as soon as both levels are low. Software may clear the pending bit. A warm reset keeps the enables and the pending bit. A cold reset clears them.

Top module: `watch_unit`

## Requirements
- R1: With `reg_sel`=0 the address register is accessed. Bits 31:3 hold the watched address, bit 2 is the fetch enable, bit 1 the load enable and bit 0 the store enable. A write is read back unchanged.
- R2: With `reg_sel`=1 the qualifier register is accessed. Bits 11:3 hold the mask, bits 23:16 the identifier, bit 30 the global bit and bit 31 the pending bit. All other bits read 0.
- R3: A fetch with `if_valid`=1, the fetch enable set and a matching address raises `watch_exc`. A mismatch in any compared bit, or a cleared enable, raises nothing.
- R4: A data access uses the load enable when `d_is_store`=0 and the store enable when `d_is_store`=1. The enable of the other data type has no effect.
- R5: Address bits 2:0 never take part in the comparison.
- R6: A 1 in mask bit j removes address bit j+3 from the comparison. Address bits above 11 are always compared.
- R7: With the global bit at 0, a hit also requires `cur_asid` to equal the stored identifier. With the global bit at 1, the identifier is ignored.
- R8: `watch_exc` is high in the cycle after the hit and lasts one cycle. A fetch hit and a data hit in the same cycle give one request.
- R9: A hit while `exl` or `erl` is 1 raises no request and sets the pending bit (`watch_pend`).
- R10: When the pending bit is set and both `exl` and `erl` are 0, `watch_exc` rises in the next cycle and the pending bit clears.
- R11: A qualifier write with bit 31 at 0 clears the pending bit, and a write with bit 31 at 1 leaves it unchanged. A blocked hit in the same cycle as a clearing write leaves the bit set.
- R12: A cold reset (`cold_rst_n`=0) clears the three enables, the pending bit and `watch_exc`. A warm reset (`warm_rst_n`=0) holds `watch_exc` at 0 and keeps the pending bit and all register contents; register writes and hits during it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Cold reset, active low, synchronous |
| warm_rst_n | input | 1 | Warm reset, active low, synchronous |
| reg_sel | input | 1 | Register select: 0 address, 1 qualifier |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| if_valid | input | 1 | Fetch address valid |
| if_addr | input | 32 | Fetch virtual address |
| d_valid | input | 1 | Data access valid |
| d_is_store | input | 1 | Data access is a store (else load) |
| d_addr | input | 32 | Data virtual address |
| cur_asid | input | 8 | Current address-space identifier |
| exl | input | 1 | Processor at exception level |
| erl | input | 1 | Processor at error level |
| watch_exc | output | 1 | Watch exception request (registered) |
| watch_pend | output | 1 | Deferred watch pending |

## Verification
Two pairs of events can fall in one cycle. In the first, a software write that clears the pending bit meets a hit taken while the level inputs block the request. The bench drives the write with bit 31 low in the same cycle as a fetch hit with `exl` high, then judges the result by the pending bit and by the later delivery once `exl` drops. In the second, a fetch hit and a data hit arrive together; the bench expects exactly one single-cycle request. Around these, the bench sweeps every address bit, several mask patterns, all eight enable combinations against all three access kinds, and every level-input combination, with each expected value computed from the bit positions.

// File: rtl/watch_pkg.sv
package watch_pkg;
    localparam int unsigned VA_W       = 32;
    localparam int unsigned ASID_W     = 8;
    localparam int unsigned MASK_W     = 9;
    localparam int unsigned DW_LSB     = 3;
    localparam int unsigned TAG_W      = VA_W - DW_LSB;
    localparam int unsigned N_PORTS    = 2;
    // qualifier register bit positions
    localparam int unsigned Q_MASK_LSB = DW_LSB;
    localparam int unsigned Q_ASID_LSB = 16;
    localparam int unsigned Q_GLOB_BIT = VA_W - 2;
    localparam int unsigned Q_PEND_BIT = VA_W - 1;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic             en_fetch;
        logic             en_load;
        logic             en_store;
    } wadr_t;

    typedef struct packed {
        logic              glob;
        logic [ASID_W-1:0] asid;
        logic [MASK_W-1:0] mask;
    } wqual_t;

    typedef struct packed {
        wadr_t  adr;
        wqual_t qual;
    } wregs_t;

    typedef struct packed {
        logic exc;
        logic pend;
    } wdefer_t;
endpackage

// File: rtl/watch_cmp.sv
module watch_cmp
    import watch_pkg::*;
(
    input  logic [TAG_W-1:0]  tag,
    input  logic [MASK_W-1:0] mask,
    input  logic              asid_ok,
    input  logic              valid,
    input  logic              enable,
    input  logic [VA_W-1:0]   addr,
    output logic              hit
);
    logic [TAG_W-1:0] ignore;
    logic [TAG_W-1:0] diff;

    always_comb begin
        ignore             = '0;
        ignore[MASK_W-1:0] = mask;
        diff               = (addr[VA_W-1:DW_LSB] ^ tag) & ~ignore;
        hit                = valid && enable && asid_ok && (diff == '0);
    end
endmodule

// File: rtl/watch_regs.sv
module watch_regs
    import watch_pkg::*;
(
    input  logic            clk,
    input  logic            cold_rst_n,
    input  logic            warm_rst_n,
    input  logic            sel,
    input  logic            we,
    input  logic [VA_W-1:0] wdata,
    input  logic            pend_in,
    output wadr_t           adr,
    output wqual_t          qual,
    output logic [VA_W-1:0] rdata,
    output logic            sw_clr
);
    wregs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        sw_clr = 1'b0;
        if (we && warm_rst_n) begin
            if (!sel) begin
                r_d.adr = wadr_t'(wdata);
            end else begin
                r_d.qual.glob = wdata[Q_GLOB_BIT];
                r_d.qual.asid = wdata[Q_ASID_LSB +: ASID_W];
                r_d.qual.mask = wdata[Q_MASK_LSB +: MASK_W];
                sw_clr        = !wdata[Q_PEND_BIT];
            end
        end
        rdata = '0;
        if (!sel) begin
            rdata = VA_W'(r_q.adr);
        end else begin
            rdata[Q_PEND_BIT]               = pend_in;
            rdata[Q_GLOB_BIT]               = r_q.qual.glob;
            rdata[Q_ASID_LSB +: ASID_W]     = r_q.qual.asid;
            rdata[Q_MASK_LSB +: MASK_W]     = r_q.qual.mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!cold_rst_n) begin
            r_q.adr.en_fetch <= 1'b0;
            r_q.adr.en_load  <= 1'b0;
            r_q.adr.en_store <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign adr  = r_q.adr;
    assign qual = r_q.qual;
endmodule

// File: rtl/watch_defer.sv
module watch_defer
    import watch_pkg::*;
(
    input  logic clk,
    input  logic cold_rst_n,
    input  logic warm_rst_n,
    input  logic exl,
    input  logic erl,
    input  logic hit,
    input  logic sw_clr,
    output logic exc,
    output logic pend
);
    wdefer_t s_d, s_q;
    logic    blocked;

    always_comb begin
        s_d     = s_q;
        blocked = exl || erl;
        if (!warm_rst_n) begin
            s_d.exc = 1'b0;
        end else begin
            s_d.exc = !blocked && (hit || s_q.pend);
            if (sw_clr)         s_d.pend = 1'b0;
            if (!blocked)       s_d.pend = 1'b0;
            if (blocked && hit) s_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!cold_rst_n) s_q <= '0;
        else             s_q <= s_d;
    end

    assign exc  = s_q.exc;
    assign pend = s_q.pend;
endmodule

// File: rtl/watch_unit.sv
module watch_unit
    import watch_pkg::*;
(
    input  logic              clk,
    input  logic              cold_rst_n,
    input  logic              warm_rst_n,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [VA_W-1:0]   reg_wdata,
    output logic [VA_W-1:0]   reg_rdata,
    input  logic              if_valid,
    input  logic [VA_W-1:0]   if_addr,
    input  logic              d_valid,
    input  logic              d_is_store,
    input  logic [VA_W-1:0]   d_addr,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic              exl,
    input  logic              erl,
    output logic              watch_exc,
    output logic              watch_pend
);
    wadr_t             adr;
    wqual_t            qual;
    logic              sw_clr;
    logic              asid_ok;
    logic              hit_any;
    logic [2:0]        en_vec;
    logic [N_PORTS-1:0] p_valid, p_en, p_hit;
    logic [VA_W-1:0]   p_addr [N_PORTS];

    watch_regs u_regs (
        .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
        .sel(reg_sel), .we(reg_we), .wdata(reg_wdata), .pend_in(watch_pend),
        .adr(adr), .qual(qual), .rdata(reg_rdata), .sw_clr(sw_clr)
    );

    always_comb begin
        asid_ok    = qual.glob || (cur_asid == qual.asid);
        en_vec     = {adr.en_fetch, adr.en_load, adr.en_store};
        p_valid[0] = if_valid;
        p_en[0]    = adr.en_fetch;
        p_addr[0]  = if_addr;
        p_valid[1] = d_valid;
        p_en[1]    = d_is_store ? adr.en_store : adr.en_load;
        p_addr[1]  = d_addr;
    end

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        watch_cmp u_cmp (
            .tag(adr.tag), .mask(qual.mask), .asid_ok(asid_ok),
            .valid(p_valid[p]), .enable(p_en[p]), .addr(p_addr[p]),
            .hit(p_hit[p])
        );
    end

    assign hit_any = |p_hit;

    watch_defer u_defer (
        .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
        .exl(exl), .erl(erl), .hit(hit_any), .sw_clr(sw_clr),
        .exc(watch_exc), .pend(watch_pend)
    );
endmodule

// File: rtl/watch_unit_chk.sv
module watch_unit_chk (
    input logic       clk,
    input logic       cold_rst_n,
    input logic       warm_rst_n,
    input logic       exl,
    input logic       erl,
    input logic       hit_any,
    input logic       sw_clr,
    input logic [2:0] en_vec,
    input logic       watch_exc,
    input logic       watch_pend
);
    // R9
    exc_only_unblocked_chk: assert property (@(posedge clk)
        disable iff (!cold_rst_n || !warm_rst_n)
        watch_exc |-> $past(!exl && !erl));

    // R9
    blocked_hit_pends_chk: assert property (@(posedge clk)
        disable iff (!cold_rst_n || !warm_rst_n)
        ((exl || erl) && hit_any) |=> watch_pend);

    // R8
    hit_latency_chk: assert property (@(posedge clk)
        disable iff (!cold_rst_n || !warm_rst_n)
        (!exl && !erl && hit_any) |=> watch_exc);

    // R10
    pend_delivery_chk: assert property (@(posedge clk)
        disable iff (!cold_rst_n || !warm_rst_n)
        (watch_pend && !exl && !erl) |=> (watch_exc && !watch_pend));

    // R11
    sw_clear_chk: assert property (@(posedge clk)
        disable iff (!cold_rst_n || !warm_rst_n)
        (sw_clr && !hit_any) |=> !watch_pend);

    // R12
    cold_reset_chk: assert property (@(posedge clk)
        !cold_rst_n |=> (!watch_pend && !watch_exc && en_vec == 3'b000));

    // R12
    warm_reset_chk: assert property (@(posedge clk)
        disable iff (!cold_rst_n)
        !warm_rst_n |=> (!watch_exc && $stable(watch_pend)));
endmodule

bind watch_unit watch_unit_chk u_chk (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
    .exl(exl), .erl(erl), .hit_any(hit_any), .sw_clr(sw_clr),
    .en_vec(en_vec), .watch_exc(watch_exc), .watch_pend(watch_pend)
);

// File: tb/watch_unit_test.sv
module watch_unit_test;
    logic        clk = 1'b0;
    logic        cold_rst_n, warm_rst_n;
    logic        reg_sel, reg_we;
    logic [31:0] reg_wdata, reg_rdata;
    logic        if_valid, d_valid, d_is_store;
    logic [31:0] if_addr, d_addr;
    logic [7:0]  cur_asid;
    logic        exl, erl;
    logic        watch_exc, watch_pend;

    int checks = 0;
    int errors = 0;

    localparam logic [31:0] BASE = 32'h1234_5678;
    localparam logic [7:0]  ASID = 8'h5A;

    always #10 clk = ~clk;

    watch_unit uut (
        .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
        .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .if_valid(if_valid), .if_addr(if_addr), .d_valid(d_valid),
        .d_is_store(d_is_store), .d_addr(d_addr), .cur_asid(cur_asid),
        .exl(exl), .erl(erl), .watch_exc(watch_exc), .watch_pend(watch_pend)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic sel, logic [31:0] data);
        reg_sel = sel; reg_we = 1'b1; reg_wdata = data;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(logic sel, logic [31:0] mask, logic [31:0] exp, string tag);
        reg_sel = sel;
        #1;
        chk(tag, reg_rdata & mask, exp);
    endtask

    function automatic logic [31:0] qword(logic pend, logic g, logic [7:0] a, logic [8:0] m);
        return (32'(pend) << 31) | (32'(g) << 30) | (32'(a) << 16) | (32'(m) << 3);
    endfunction

    task automatic drive(int kind, logic [31:0] a);
        if_valid = (kind == 0); if_addr = a;
        d_valid = (kind != 0); d_is_store = (kind == 2); d_addr = a;
    endtask

    task automatic idle();
        if_valid = 1'b0; d_valid = 1'b0; d_is_store = 1'b0;
    endtask

    // kind: 0 fetch, 1 load, 2 store
    task automatic probe(int kind, logic [31:0] a, logic exp, string tag);
        drive(kind, a);
        tick();
        chk(tag, 32'(watch_exc), 32'(exp));
        idle();
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [8:0] pats [4];
        pats[0] = 9'h000; pats[1] = 9'h155; pats[2] = 9'h0AA; pats[3] = 9'h1FF;
        cold_rst_n = 1'b0; warm_rst_n = 1'b1;
        reg_sel = 1'b0; reg_we = 1'b0; reg_wdata = '0;
        if_addr = '0; d_addr = '0; cur_asid = ASID; exl = 1'b0; erl = 1'b0;
        idle();
        repeat (3) tick();
        // R12 cold reset state
        chk("R12 exc after cold", 32'(watch_exc), 0);
        chk("R12 pend after cold", 32'(watch_pend), 0);
        rd_chk(1'b0, 32'h7, 32'h0, "R12 enables after cold");
        cold_rst_n = 1'b1;
        tick();

        // R1 / R2 register layout
        wr(1'b0, BASE | 32'h7);
        rd_chk(1'b0, 32'hFFFF_FFFF, BASE | 32'h7, "R1 address readback");
        wr(1'b1, 32'hFFFF_FFFF);
        rd_chk(1'b1, 32'hFFFF_FFFF, qword(1'b0, 1'b1, 8'hFF, 9'h1FF), "R2 qualifier readback");
        wr(1'b1, qword(1'b1, 1'b1, ASID, 9'h000));
        rd_chk(1'b1, 32'hFFFF_FFFF, qword(1'b0, 1'b1, ASID, 9'h000), "R2 qualifier fields");

        // R3 / R5 address bit sweep
        for (int i = 0; i < 32; i++)
            probe(0, BASE ^ (32'h1 << i), (i < 3), (i < 3) ? "R5 low bits ignored" : "R3 addr bit");
        probe(0, BASE, 1'b1, "R3 exact fetch hit");

        // R6 mask sweep on loads
        for (int p = 0; p < 4; p++) begin
            wr(1'b1, qword(1'b1, 1'b1, ASID, pats[p]));
            for (int j = 0; j < 9; j++)
                probe(1, BASE ^ (32'h8 << j), pats[p][j], "R6 mask bit");
        end
        probe(1, BASE ^ 32'h1000, 1'b0, "R6 bit12 always compared");
        wr(1'b1, qword(1'b1, 1'b1, ASID, 9'h000));

        // R3 / R4 enable combinations against access kinds
        for (int e = 0; e < 8; e++) begin
            wr(1'b0, BASE | 32'(e));
            for (int k = 0; k < 3; k++)
                probe(k, BASE, e[2-k], (k == 0) ? "R3 fetch enable" : "R4 data enable");
        end
        wr(1'b0, BASE | 32'h7);

        // R7 identifier qualification
        for (int g = 0; g < 2; g++) begin
            logic [7:0] cands [3];
            cands[0] = ASID; cands[1] = ASID ^ 8'h01; cands[2] = ASID ^ 8'h80;
            wr(1'b1, qword(1'b1, g[0], ASID, 9'h000));
            for (int c = 0; c < 3; c++) begin
                cur_asid = cands[c];
                probe(0, BASE, g[0] || (c == 0), "R7 identifier");
            end
        end
        cur_asid = ASID;
        wr(1'b1, qword(1'b1, 1'b1, ASID, 9'h000));

        // R8 simultaneous fetch and data hit
        if_valid = 1'b1; if_addr = BASE; d_valid = 1'b1; d_is_store = 1'b1; d_addr = BASE;
        tick();
        chk("R8 dual hit request", 32'(watch_exc), 1);
        idle();
        tick();
        chk("R8 single cycle pulse", 32'(watch_exc), 0);
        if_valid = 1'b1; if_addr = BASE ^ 32'h100; d_valid = 1'b1; d_addr = BASE;
        tick();
        chk("R8 data hit with fetch miss", 32'(watch_exc), 1);
        idle();
        tick();

        // R9 / R10 deferral for every blocking combination
        for (int lv = 1; lv < 4; lv++) begin
            exl = lv[0]; erl = lv[1];
            drive(0, BASE);
            tick();
            chk("R9 blocked no request", 32'(watch_exc), 0);
            chk("R9 pending set", 32'(watch_pend), 1);
            idle();
            tick();
            chk("R9 still deferred", 32'(watch_exc), 0);
            chk("R9 pending held", 32'(watch_pend), 1);
            exl = 1'b0; erl = 1'b0;
            tick();
            chk("R10 delivered", 32'(watch_exc), 1);
            chk("R10 pending cleared", 32'(watch_pend), 0);
            tick();
            chk("R10 single delivery", 32'(watch_exc), 0);
        end

        // R11 software clear
        exl = 1'b1;
        drive(0, BASE);
        tick();
        idle();
        rd_chk(1'b1, 32'h8000_0000, 32'h8000_0000, "R11 pending readable");
        wr(1'b1, qword(1'b1, 1'b1, ASID, 9'h000));
        chk("R11 write one keeps", 32'(watch_pend), 1);
        wr(1'b1, qword(1'b0, 1'b1, ASID, 9'h000));
        chk("R11 write zero clears", 32'(watch_pend), 0);
        rd_chk(1'b1, 32'h8000_0000, 32'h0, "R11 cleared readback");
        wr(1'b1, qword(1'b1, 1'b1, ASID, 9'h000));
        chk("R11 write one no set", 32'(watch_pend), 0);
        drive(0, BASE);
        wr(1'b1, qword(1'b0, 1'b1, ASID, 9'h000));
        idle();
        chk("R11 blocked hit beats clear", 32'(watch_pend), 1);
        exl = 1'b0;
        tick();
        chk("R11 late delivery", 32'(watch_exc), 1);
        tick();

        // R12 warm reset keeps state
        exl = 1'b1;
        drive(0, BASE);
        tick();
        exl = 1'b0;
        warm_rst_n = 1'b0;
        reg_sel = 1'b0; reg_we = 1'b1; reg_wdata = 32'h0;
        tick();
        reg_we = 1'b0;
        chk("R12 warm exc low", 32'(watch_exc), 0);
        chk("R12 warm pend kept", 32'(watch_pend), 1);
        idle();
        warm_rst_n = 1'b1;
        rd_chk(1'b0, 32'hFFFF_FFFF, BASE | 32'h7, "R12 warm write ignored");
        tick();
        chk("R12 delivery after warm", 32'(watch_exc), 1);
        tick();

        // R12 cold reset clears pending and enables
        exl = 1'b1;
        drive(0, BASE);
        tick();
        idle();
        cold_rst_n = 1'b0;
        tick();
        chk("R12 cold clears pend", 32'(watch_pend), 0);
        rd_chk(1'b0, 32'h7, 32'h0, "R12 cold clears enables");
        cold_rst_n = 1'b1; exl = 1'b0;
        tick();
        probe(0, BASE, 1'b0, "R12 disabled after cold");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule